// File: doc/BRIEF.md
# Reset Qualifier and Boot Fetch Sequencer

This block sits between the chip's external active-low reset input and the processor core. The external level may move at any moment relative to the core clock, so it first passes through a flip-flop synchronizer. A qualifier then accepts it only after it has stayed asserted for more than four clock periods. A qualified reset raises the internal reset, which every downstream register uses as a synchronous clear. It also ends any boot sequence that is still under way. When the external input returns high, the internal reset drops cleanly on a clock edge through a two-stage release pipeline.

Once the internal reset has dropped, a sequencer counts a fixed delay of seven clock edges. It then issues a single one-cycle fetch request whose address is the hard-wired boot vector 0xFFFF0. The block also drives enables that put the upper address pins and the bus-control pins into their normal function, so that the first fetch reaches the right location.

Top module: `boot_reset_ctrl`

## Requirements
- R1: `rst_in_n` is sampled only on rising clock edges through a two-flop synchronizer, so a low glitch that starts and ends between two edges has no effect on any output.
- R2: When `rst_in_n` is sampled low on 5 consecutive rising edges, `core_rst` goes high right after the 8th rising edge counted from the first edge that sampled it low, and stays high while the input stays low.
- R3: A low pulse on `rst_in_n` that is sampled on 4 or fewer consecutive edges leaves `core_rst` low, produces no `fetch_go` pulse, and leaves `fetch_addr` unchanged.
- R4: After a qualified reset, `core_rst` falls right after the 5th rising edge counted from the first edge that samples `rst_in_n` high.
- R5: While `core_rst` is high, `fetch_go` and `fetch_addr` are cleared to 0 from the next edge on, and a delay count in progress is abandoned.
- R6: `fetch_go` is high for exactly one cycle, starting right after the 7th rising edge counted from the edge at which `core_rst` fell. From that cycle until the next reset, `fetch_addr` equals 0xFFFF0.
- R7: Only one `fetch_go` pulse is produced per reset release. No further pulse appears until another qualified reset has been asserted and released.
- R8: `upaddr_norm` (3 bits) and `busctl_norm` (3 bits) are forced to all ones by `core_rst` and keep that value afterwards, including in the cycle of `fetch_go`.
- R9: If a new reset is qualified while the fetch delay is still running, the pending fetch is cancelled. Exactly one fetch then follows the later release, on the R6 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_in_n | input | 1 | External reset, active low, asynchronous to `clk` |
| core_rst | output | 1 | Qualified internal reset, active high, synchronous to `clk` |
| fetch_go | output | 1 | One-cycle request to start the first instruction fetch |
| fetch_addr | output | 20 | Address of the first fetch (boot vector) |
| upaddr_norm | output | 3 | Normal-function enables for the upper address pins |
| busctl_norm | output | 3 | Normal-function enables for the bus-control pins |

## Verification
Two events can land on the same clock edge: the end of the seven-edge fetch delay and the qualification of a fresh reset. The bench releases reset and then pulls the input low again, timed so that `core_rst` rises one edge before the delay would expire. It judges the result cycle by cycle: no pulse may appear at the edge where the first fetch was due, `fetch_addr` must read 0 after it, and exactly one pulse must follow the later release, seven edges after `core_rst` falls.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // Width of the instruction fetch address and the hard-wired boot vector.
    localparam int          ADDR_W   = 20;
    localparam logic [19:0] BOOT_VEC = 20'hFFFF0;

    // Sequencer states; the all-zero code is a parked state that does
    // nothing until the first qualified reset arrives.
    typedef enum logic [1:0] {
        BOOT_IDLE = 2'd0,
        BOOT_HOLD = 2'd1,
        BOOT_WAIT = 2'd2,
        BOOT_RUN  = 2'd3
    } boot_st_e;

    // First-fetch request bundle.
    typedef struct packed {
        logic              go;
        logic [ADDR_W-1:0] addr;
    } fetch_req_t;

    // Counter width able to hold values 0..limit.
    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic rst_req
);

    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    logic [NS-1:0] sync_q;

    // Chain of plain flops; the inverted pad level enters stage 0.
    always_ff @(posedge clk) begin
        sync_q <= {sync_q[NS-2:0], ~rst_in_n};
    end

    assign rst_req = sync_q[NS-1];

endmodule

// File: rtl/brc_qual.sv
module brc_qual #(
    parameter int QUAL_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_req,
    output logic qual_lvl
);

    import brc_pkg::*;

    localparam int CW               = cnt_width(QUAL_CYCLES);
    localparam logic [CW-1:0] LAST  = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive synchronized reset samples, saturating at LAST.
    always_ff @(posedge clk) begin
        if (!rst_req) begin
            run_cnt  <= '0;
            qual_lvl <= 1'b0;
        end else begin
            if (run_cnt != LAST) begin
                run_cnt <= run_cnt + 1'b1;
            end
            qual_lvl <= (run_cnt == LAST);
        end
    end

    AST_SHORT_IGNORED: assert property (@(posedge clk)
        !rst_req |=> !qual_lvl);                                  // R3
    AST_QUAL_NEEDS_REQ: assert property (@(posedge clk)
        $rose(qual_lvl) |-> $past(rst_req));                      // R2

endmodule

// File: rtl/brc_release.sv
module brc_release #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic qual_lvl,
    output logic core_rst
);

    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    logic [NS-1:0] rel_q;

    // Assertion loads all stages at once; release drains them one per edge.
    always_ff @(posedge clk) begin
        if (qual_lvl) begin
            rel_q <= '1;
        end else begin
            rel_q <= {rel_q[NS-2:0], 1'b0};
        end
    end

    assign core_rst = rel_q[NS-1];

    AST_ASSERT_FOLLOWS: assert property (@(posedge clk)
        qual_lvl |=> core_rst);                                   // R2
    AST_RELEASE_HELD: assert property (@(posedge clk)
        $fell(qual_lvl) |=> core_rst);                            // R4

endmodule

// File: rtl/brc_boot.sv
module brc_boot #(
    parameter int DELAY    = 7,
    parameter int UPADDR_W = 3,
    parameter int BUSCTL_W = 3
) (
    input  logic                    clk,
    input  logic                    core_rst,
    output brc_pkg::fetch_req_t     fetch,
    output logic [UPADDR_W-1:0]     upaddr_norm,
    output logic [BUSCTL_W-1:0]     busctl_norm
);

    import brc_pkg::*;

    localparam int DW               = cnt_width(DELAY);
    localparam logic [DW-1:0] FIRE  = DW'((DELAY < 1) ? 0 : DELAY - 1);
    localparam bit   SHORT          = (DELAY <= 1);

    boot_st_e      st;
    logic [DW-1:0] dly_cnt;

    always_ff @(posedge clk) begin
        if (core_rst) begin
            st          <= BOOT_HOLD;
            dly_cnt     <= '0;
            fetch       <= '0;
            upaddr_norm <= '1;
            busctl_norm <= '1;
        end else begin
            case (st)
                BOOT_IDLE: begin
                    fetch.go <= 1'b0;
                end
                BOOT_HOLD: begin
                    // First edge after release.
                    if (SHORT) begin
                        fetch.go   <= 1'b1;
                        fetch.addr <= BOOT_VEC;
                        st         <= BOOT_RUN;
                    end else begin
                        dly_cnt <= DW'(1);
                        st      <= BOOT_WAIT;
                    end
                end
                BOOT_WAIT: begin
                    if (dly_cnt == FIRE) begin
                        fetch.go   <= 1'b1;
                        fetch.addr <= BOOT_VEC;
                        st         <= BOOT_RUN;
                    end else begin
                        dly_cnt <= dly_cnt + 1'b1;
                    end
                end
                BOOT_RUN: begin
                    fetch.go <= 1'b0;
                end
                default: begin
                    fetch.go <= 1'b0;
                    st       <= BOOT_IDLE;
                end
            endcase
        end
    end

    AST_RST_QUIET: assert property (@(posedge clk)
        core_rst |=> (!fetch.go && fetch.addr == '0));            // R5
    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (core_rst)
        fetch.go |=> !fetch.go);                                  // R6
    AST_FETCH_VECTOR: assert property (@(posedge clk) disable iff (core_rst)
        fetch.go |-> fetch.addr == BOOT_VEC);                     // R6
    AST_FETCH_ONCE: assert property (@(posedge clk) disable iff (core_rst)
        (!fetch.go && fetch.addr == BOOT_VEC) |=> !fetch.go);     // R7
    AST_PINS_NORMAL: assert property (@(posedge clk) disable iff (core_rst)
        fetch.go |-> (&upaddr_norm && &busctl_norm));             // R8

endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 5,
    parameter int REL_STAGES  = 2,
    parameter int FETCH_DELAY = 7,
    parameter int UPADDR_W    = 3,
    parameter int BUSCTL_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_in_n,
    output logic                       core_rst,
    output logic                       fetch_go,
    output logic [brc_pkg::ADDR_W-1:0] fetch_addr,
    output logic [UPADDR_W-1:0]        upaddr_norm,
    output logic [BUSCTL_W-1:0]        busctl_norm
);

    import brc_pkg::*;

    logic       rst_req;
    logic       qual_lvl;
    fetch_req_t fetch;

    brc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_in_n (rst_in_n),
        .rst_req  (rst_req)
    );

    brc_qual #(.QUAL_CYCLES(QUAL_CYCLES)) i_qual (
        .clk      (clk),
        .rst_req  (rst_req),
        .qual_lvl (qual_lvl)
    );

    brc_release #(.STAGES(REL_STAGES)) i_release (
        .clk      (clk),
        .qual_lvl (qual_lvl),
        .core_rst (core_rst)
    );

    brc_boot #(
        .DELAY    (FETCH_DELAY),
        .UPADDR_W (UPADDR_W),
        .BUSCTL_W (BUSCTL_W)
    ) i_boot (
        .clk         (clk),
        .core_rst    (core_rst),
        .fetch       (fetch),
        .upaddr_norm (upaddr_norm),
        .busctl_norm (busctl_norm)
    );

    assign fetch_go   = fetch.go;
    assign fetch_addr = fetch.addr;

endmodule

// File: tb/test_boot_reset_ctrl.sv
module test_boot_reset_ctrl;

    localparam logic [19:0] VEC = 20'hFFFF0;

    logic        clk = 1'b0;
    logic        rst_in_n = 1'b0;
    logic        core_rst;
    logic        fetch_go;
    logic [19:0] fetch_addr;
    logic [2:0]  upaddr_norm;
    logic [2:0]  busctl_norm;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    boot_reset_ctrl i_boot_reset_ctrl (
        .clk         (clk),
        .rst_in_n    (rst_in_n),
        .core_rst    (core_rst),
        .fetch_go    (fetch_go),
        .fetch_addr  (fetch_addr),
        .upaddr_norm (upaddr_norm),
        .busctl_norm (busctl_norm)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Generic window: edges counted from the next posedge as k=1.
    // low_k/rel_k: drive low/high at the negedge after edge k (0 = before k=1).
    task automatic run_win(input int n, input int low_k, input int rel_k,
                           input int on_k, input int off_k, input int go_k,
                           input string req);
        if (low_k == 0) rst_in_n = 1'b0;
        if (rel_k == 0) rst_in_n = 1'b1;
        for (int k = 1; k <= n; k++) begin
            bit er, eg;
            step();
            er = (k >= on_k) && (k < off_k);
            eg = (k == go_k);
            chk(core_rst == er, req, $sformatf("core_rst k=%0d", k), 32'(core_rst), 32'(er));
            chk(fetch_go == eg, req, $sformatf("fetch_go k=%0d", k), 32'(fetch_go), 32'(eg));
            if (k == low_k) rst_in_n = 1'b0;
            if (k == rel_k) rst_in_n = 1'b1;
        end
    endtask

    // R2 R5 R8: state after a long reset from power-up
    task automatic t_reset_state();
        repeat (20) step();
        chk(core_rst == 1'b1, "R2", "core_rst held", 32'(core_rst), 32'd1);
        chk(fetch_go == 1'b0, "R5", "fetch_go in reset", 32'(fetch_go), 32'd0);
        chk(fetch_addr == 20'h0, "R5", "fetch_addr in reset", 32'(fetch_addr), 32'd0);
        chk(upaddr_norm == 3'b111, "R8", "upaddr_norm", 32'(upaddr_norm), 32'h7);
        chk(busctl_norm == 3'b111, "R8", "busctl_norm", 32'(busctl_norm), 32'h7);
    endtask

    // R4 R6: release timing and first fetch
    task automatic t_first_release();
        run_win(16, -1, 0, 0, 5, 12, "R4/R6");
        chk(fetch_addr == VEC, "R6", "fetch_addr after fetch", 32'(fetch_addr), 32'(VEC));
        chk(upaddr_norm == 3'b111 && busctl_norm == 3'b111, "R8", "pins after fetch",
            32'({upaddr_norm, busctl_norm}), 32'h3f);
    endtask

    // R7: no further pulse while running
    task automatic t_once();
        run_win(30, -1, -1, -1, -1, -1, "R7");
        chk(fetch_addr == VEC, "R7", "fetch_addr steady", 32'(fetch_addr), 32'(VEC));
    endtask

    // R1: glitch between edges
    task automatic t_glitch();
        @(posedge clk);
        #2 rst_in_n = 1'b0;
        #2 rst_in_n = 1'b1;
        run_win(20, -1, -1, -1, -1, -1, "R1");
        chk(fetch_addr == VEC, "R1", "fetch_addr after glitch", 32'(fetch_addr), 32'(VEC));
    endtask

    // R3: 4-edge pulse is rejected
    task automatic t_short();
        run_win(25, 0, 4, -1, -1, -1, "R3");
        chk(fetch_addr == VEC, "R3", "fetch_addr after short pulse", 32'(fetch_addr), 32'(VEC));
    endtask

    // R2: 5-edge pulse qualifies; full sequence follows
    task automatic t_min_pulse();
        run_win(22, 0, 5, 8, 10, 17, "R2");
        chk(fetch_addr == VEC, "R2", "fetch_addr after min pulse", 32'(fetch_addr), 32'(VEC));
    endtask

    // R9: new reset qualifies one edge before the pending fetch
    task automatic t_collide();
        rst_in_n = 1'b0;
        for (int k = 1; k <= 30; k++) begin
            bit er, eg;
            step();
            er = (k >= 8 && k < 10) || (k >= 16 && k < 19);
            eg = (k == 26);
            chk(core_rst == er, "R9", $sformatf("core_rst k=%0d", k), 32'(core_rst), 32'(er));
            chk(fetch_go == eg, "R9", $sformatf("fetch_go k=%0d", k), 32'(fetch_go), 32'(eg));
            if (k == 18)
                chk(fetch_addr == 20'h0, "R5", "fetch_addr cleared", 32'(fetch_addr), 32'd0);
            if (k == 26)
                chk(fetch_addr == VEC, "R9", "fetch_addr at fetch", 32'(fetch_addr), 32'(VEC));
            if (k == 5)  rst_in_n = 1'b1;
            if (k == 8)  rst_in_n = 1'b0;
            if (k == 14) rst_in_n = 1'b1;
        end
    endtask

    initial begin
        t_reset_state();
        t_first_release();
        t_once();
        t_glitch();
        t_short();
        t_min_pulse();
        t_collide();
        t_once();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule